// File: doc/BRIEF.md
# Paired-Bit Multi-Level Cell Write/Read Sequencer

This block sits between a request source and an array of two-bit magnetic memory cells. It stores two neighbouring data words in one row of cells. Word A goes into the hard (less significant) bit of each cell and word B goes into the soft (more significant) bit. A high-current pulse sets the hard bit and also copies that value into the soft bit. A later low-current pulse changes only the soft bit. The sequencer uses this: the first write step drives every cell with A at high current, so the second step only has to touch the cells where B differs from A. When A equals B, the second step is skipped.

A request carries a mode (paired or soft-only), a direction, an address and two data words. A paired read takes two compare steps. The first step uses the middle reference and yields the soft bits. The second step picks the lower or upper reference for each cell from that first result and yields the hard bits. Soft-only requests reach just the soft bits in one step. Only one request is handled at a time. Read data is returned on a valid/ready response channel. A completed write raises a one-cycle done strobe together with the number of cells that received the low-current pulse.

Top module: `mlc_pair_seq`

Command codes on `arr_cmd`:

| Code | Meaning |
|------|---------|
| 0 | idle |
| 1 | high-current write |
| 2 | low-current write |
| 3 | compare against the middle reference |
| 4 | compare against the lower or upper reference |

Cell levels and compare results:

- The level of a cell is 2·soft + hard.
- Reference 0 sits between levels 1 and 2.
- Reference 1 sits between levels 0 and 1.
- Reference 2 sits between levels 2 and 3.
- `arr_cmp[i]` is 1 when the level of cell i is above the reference applied to it.

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `wr_done` is 0 and `arr_cmd` is 0 (idle).
- R2: A paired write first issues command 1 for exactly HARD_CYC cycles, with `arr_mask` all ones and `arr_wdata` equal to word A.
- R3: A paired write then issues command 2 for exactly SOFT_CYC cycles, with `arr_mask` equal to A xor B and `arr_wdata` equal to B. When A equals B, command 2 is never issued.
- R4: No compare command (3 or 4) appears during any write, so stored values are never pre-read.
- R5: A paired read issues command 3 for READ_CYC cycles and then command 4 for READ_CYC cycles. During command 4, bit i of `arr_ref_hi` equals the soft bit of cell i (1 selects reference 2, 0 selects reference 1). The read returns the hard bits on `rsp_a` and the soft bits on `rsp_b`.
- R6: A soft-only write issues only command 2, for SOFT_CYC cycles, with `arr_mask` all ones and `arr_wdata` equal to B. The hard bits keep the value they held before.
- R7: A soft-only read issues only command 3, for READ_CYC cycles. It returns the soft bits on `rsp_b` and zero on `rsp_a`.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the write completes or the read response is taken. While any command other than idle is on `arr_cmd`, `req_ready` is 0.
- R9: `wr_done` is a one-cycle pulse in the cycle after the last write step ends. Alongside it, `wr_flip_cnt` gives the number of cells driven at low current: popcount(A xor B) for a paired write, W for a soft-only write.
- R10: Once raised, `rsp_valid` stays 1 with `rsp_a` and `rsp_b` stable until `rsp_ready` is seen. It is 0 in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_paired | input | 1 | 1 = both bits of each cell, 0 = soft bits only |
| req_addr | input | ADDR_W | Row address |
| req_wa | input | W | Word A (hard bits), used by paired writes |
| req_wb | input | W | Word B (soft bits) |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_a | output | W | Hard bits read back (zero for soft-only reads) |
| rsp_b | output | W | Soft bits read back |
| wr_done | output | 1 | One-cycle write completion strobe |
| wr_flip_cnt | output | $clog2(W+1) | Cells driven at low current by the finished write |
| arr_cmd | output | 3 | Cell-array command code |
| arr_addr | output | ADDR_W | Row address to the array |
| arr_mask | output | W | Per-cell write enable |
| arr_wdata | output | W | Per-cell write value |
| arr_ref_hi | output | W | Per-cell selection between reference 2 and reference 1 for command 4 |
| arr_cmp | input | W | Per-cell compare result from the array |

## Verification
The hardest case to reach from the ports is a soft bit that disagrees with its hard bit, since one high-current step always makes the two equal. That state exists only after a low-current step, and it is the case where the per-cell reference choice in the second read step matters. The bench sweeps every pair of 4-bit words through a paired write and a paired read, which produces every mix of agreeing and disagreeing cells, including the all-equal case that skips step two. It then overwrites only the soft bits with the complement and reads the row back both ways. This shows the hard bits survived and the cells read at level 1 or 2 through both reference paths.

// File: rtl/mlc_pair_pkg.sv
// Shared encodings for the paired-bit cell sequencer.
// Assumes the array decodes the command codes below as documented in the brief.
package mlc_pair_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_WR_HI  = 3'd1,
        CMD_WR_LO  = 3'd2,
        CMD_RD_MID = 3'd3,
        CMD_RD_SEL = 3'd4
    } arr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WHI,
        ST_WLO,
        ST_RSOFT,
        ST_RHARD,
        ST_RSP
    } seq_state_e;

    // Largest of three step lengths; sizes the step timer.
    function automatic int max3(input int x, input int y, input int z);
        int m;
        m = (x > y) ? x : y;
        return (m > z) ? m : z;
    endfunction

endpackage

// File: rtl/mlc_step_timer.sv
// Down-counter that measures the length of one array step.
// Assumes len >= 1. The step lasts exactly len cycles counted from the load cycle's successor.
module mlc_step_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          expire
);
    logic [TW-1:0] cnt;

    // Load len-1 on a new step, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= len - TW'(1);
        else if (cnt != '0)    cnt <= cnt - TW'(1);
    end

    // The step ends in the cycle the counter reads zero.
    always_comb expire = (cnt == '0);
endmodule

// File: rtl/mlc_popcount.sv
// Counts the set bits of a W-bit vector; used for the low-current cell count.
// Purely combinational.
module mlc_popcount #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] ones
);
    // Sum the bits one by one.
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) ones = ones + CW'(vec[i]);
    end
endmodule

// File: rtl/mlc_read_capture.sv
// Holds the soft and hard bit results of a read while the response waits.
// Assumes clear and the capture strobes never fire in the same cycle.
module mlc_read_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         cap_soft,
    input  logic         cap_hard,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] soft_q,
    output logic [W-1:0] hard_q
);
    // Soft bits come from the middle-reference compare.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) soft_q <= '0;
        else if (cap_soft)   soft_q <= cmp;
    end

    // Hard bits come from the per-cell selected-reference compare.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hard_q <= '0;
        else if (cap_hard)   hard_q <= cmp;
    end
endmodule

// File: rtl/mlc_pair_seq.sv
// Sequencer for two-bit cells holding word A in hard bits and word B in soft bits.
// The first write step uses high current with data A on all cells, which also copies A into the soft bits.
// The second step uses low current only on cells where B differs from A.
// A paired read resolves the soft bits first, then the hard bits with a reference chosen per cell.
// Assumes one request at a time and an array whose compare result settles within a step.
module mlc_pair_seq
    import mlc_pair_pkg::*;
#(
    parameter int W        = 8,
    parameter int ADDR_W   = 6,
    parameter int HARD_CYC = 20,
    parameter int SOFT_CYC = 10,
    parameter int READ_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic                   req_paired,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [W-1:0]           req_wa,
    input  logic [W-1:0]           req_wb,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [W-1:0]           rsp_a,
    output logic [W-1:0]           rsp_b,
    output logic                   wr_done,
    output logic [$clog2(W+1)-1:0] wr_flip_cnt,
    output logic [2:0]             arr_cmd,
    output logic [ADDR_W-1:0]      arr_addr,
    output logic [W-1:0]           arr_mask,
    output logic [W-1:0]           arr_wdata,
    output logic [W-1:0]           arr_ref_hi,
    input  logic [W-1:0]           arr_cmp
);
    localparam int CW   = $clog2(W + 1);
    localparam int MAXC = max3(HARD_CYC, SOFT_CYC, READ_CYC);
    localparam int TW   = $clog2(MAXC + 1);

    seq_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [W-1:0]      wa_q, wb_q;
    logic              paired_q;
    logic [W-1:0]      diff, lo_mask, soft_q, hard_q;
    logic [CW-1:0]     lo_cnt;
    logic              tmr_load, expire;
    logic [TW-1:0]     tmr_len;

    // Cells that need the low-current step.
    always_comb begin
        diff    = wa_q ^ wb_q;
        lo_mask = paired_q ? diff : '1;
    end

    mlc_popcount #(.W(W), .CW(CW)) u_pop (
        .vec  (lo_mask),
        .ones (lo_cnt)
    );

    // Choose when to start a step and how long it lasts.
    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = TW'(READ_CYC);
        case (state)
            ST_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_write) tmr_len = req_paired ? TW'(HARD_CYC) : TW'(SOFT_CYC);
                else           tmr_len = TW'(READ_CYC);
            end
            ST_WHI:   if (expire && diff != '0) begin
                tmr_load = 1'b1;
                tmr_len  = TW'(SOFT_CYC);
            end
            ST_RSOFT: if (expire && paired_q) begin
                tmr_load = 1'b1;
                tmr_len  = TW'(READ_CYC);
            end
            default: ;
        endcase
    end

    mlc_step_timer #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .expire (expire)
    );

    // Request latch, step sequencing and the write completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            addr_q      <= '0;
            wa_q        <= '0;
            wb_q        <= '0;
            paired_q    <= 1'b0;
            wr_done     <= 1'b0;
            wr_flip_cnt <= '0;
        end else begin
            wr_done <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    wa_q     <= req_wa;
                    wb_q     <= req_wb;
                    paired_q <= req_paired;
                    if (req_write) state <= req_paired ? ST_WHI : ST_WLO;
                    else           state <= ST_RSOFT;
                end
                ST_WHI: if (expire) begin
                    if (diff != '0) state <= ST_WLO;
                    else begin
                        state       <= ST_IDLE;
                        wr_done     <= 1'b1;
                        wr_flip_cnt <= '0;
                    end
                end
                ST_WLO: if (expire) begin
                    state       <= ST_IDLE;
                    wr_done     <= 1'b1;
                    wr_flip_cnt <= lo_cnt;
                end
                ST_RSOFT: if (expire) state <= paired_q ? ST_RHARD : ST_RSP;
                ST_RHARD: if (expire) state <= ST_RSP;
                ST_RSP:   if (rsp_ready) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    mlc_read_capture #(.W(W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_IDLE && req_valid),
        .cap_soft (state == ST_RSOFT && expire),
        .cap_hard (state == ST_RHARD && expire),
        .cmp      (arr_cmp),
        .soft_q   (soft_q),
        .hard_q   (hard_q)
    );

    // Array command port driven from the current step.
    always_comb begin
        arr_cmd    = CMD_IDLE;
        arr_mask   = '0;
        arr_wdata  = '0;
        arr_ref_hi = '0;
        arr_addr   = addr_q;
        case (state)
            ST_WHI: begin
                arr_cmd   = CMD_WR_HI;
                arr_mask  = '1;
                arr_wdata = wa_q;
            end
            ST_WLO: begin
                arr_cmd   = CMD_WR_LO;
                arr_mask  = lo_mask;
                arr_wdata = wb_q;
            end
            ST_RSOFT: arr_cmd = CMD_RD_MID;
            ST_RHARD: begin
                arr_cmd    = CMD_RD_SEL;
                arr_ref_hi = soft_q;
            end
            default: ;
        endcase
    end

    // Handshake outputs.
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RSP);
        rsp_a     = hard_q;
        rsp_b     = soft_q;
    end
endmodule

// File: rtl/mlc_pair_seq_chk.sv
// Property checker for mlc_pair_seq, attached by bind below.
module mlc_pair_seq_chk
    import mlc_pair_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_ready,
    input logic         rsp_valid,
    input logic         rsp_ready,
    input logic [W-1:0] rsp_a,
    input logic [W-1:0] rsp_b,
    input logic         wr_done,
    input logic [2:0]   arr_cmd,
    input logic [W-1:0] arr_mask
);
    // R2: the high-current step drives every cell.
    assert_hi_full_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd == CMD_WR_HI) |-> (&arr_mask));

    // R3: a low-current step never runs with an empty mask.
    assert_lo_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd == CMD_WR_LO) |-> (arr_mask != '0));

    // R4: a high-current step is followed by writing or idle, never a compare.
    assert_no_preread_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd == CMD_WR_HI) |=> (arr_cmd inside {CMD_WR_HI, CMD_WR_LO, CMD_IDLE}));

    // R5: compare steps enable no cell writes.
    assert_read_no_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd inside {CMD_RD_MID, CMD_RD_SEL}) |-> (arr_mask == '0));

    // R8: no new request accepted while the array is busy.
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd != CMD_IDLE) |-> !req_ready);

    // R9: the completion strobe lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    // R10: a pending response holds its data.
    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_a) && $stable(rsp_b)));
endmodule

bind mlc_pair_seq mlc_pair_seq_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_a     (rsp_a),
    .rsp_b     (rsp_b),
    .wr_done   (wr_done),
    .arr_cmd   (arr_cmd),
    .arr_mask  (arr_mask)
);

// File: tb/sim_mlc_pair_seq.sv
`timescale 1ns/1ps
// Bench: sweeps every 4-bit word pair through paired and soft-only access against a behavioural cell array.
module sim_mlc_pair_seq;
    localparam int W = 4, AW = 3, HC = 5, SC = 3, RC = 2;
    localparam int CW = $clog2(W + 1);
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_paired = 1'b0, rsp_ready = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0] req_wa = '0, req_wb = '0;
    logic req_ready, rsp_valid, wr_done;
    logic [W-1:0] rsp_a, rsp_b, arr_mask, arr_wdata, arr_ref_hi, arr_cmp;
    logic [CW-1:0] wr_flip_cnt;
    logic [2:0] arr_cmd;
    logic [AW-1:0] arr_addr;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mlc_pair_seq #(.W(W), .ADDR_W(AW), .HARD_CYC(HC), .SOFT_CYC(SC), .READ_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_paired(req_paired), .req_addr(req_addr),
        .req_wa(req_wa), .req_wb(req_wb), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_a(rsp_a), .rsp_b(rsp_b), .wr_done(wr_done), .wr_flip_cnt(wr_flip_cnt),
        .arr_cmd(arr_cmd), .arr_addr(arr_addr), .arr_mask(arr_mask), .arr_wdata(arr_wdata),
        .arr_ref_hi(arr_ref_hi), .arr_cmp(arr_cmp));

    // Behavioural cell array: a high-current write sets both bits, a low-current write sets only the soft bit.
    logic [W-1:0] soft_m [DEPTH];
    logic [W-1:0] hard_m [DEPTH];
    initial for (int i = 0; i < DEPTH; i++) begin soft_m[i] = '0; hard_m[i] = '0; end
    always @(posedge clk) begin
        for (int i = 0; i < W; i++) begin
            if (arr_cmd == 3'd1 && arr_mask[i]) begin
                hard_m[arr_addr][i] <= arr_wdata[i];
                soft_m[arr_addr][i] <= arr_wdata[i];
            end else if (arr_cmd == 3'd2 && arr_mask[i]) begin
                soft_m[arr_addr][i] <= arr_wdata[i];
            end
        end
    end
    // Sensing: level = 2*soft + hard compared against the applied reference.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            int lvl;
            lvl = 2 * int'(soft_m[arr_addr][i]) + int'(hard_m[arr_addr][i]);
            if (arr_cmd == 3'd3)      arr_cmp[i] = (lvl >= 2);
            else if (arr_cmd == 3'd4) arr_cmp[i] = arr_ref_hi[i] ? (lvl == 3) : (lvl >= 1);
            else                      arr_cmp[i] = 1'b0;
        end
    end

    // Step monitor: counts cycles of each command and flags wrong masks, data or references.
    int n_hi, n_lo, n_mid, n_sel, bad_hi, bad_lo, bad_sel, bad_rdy;
    logic [W-1:0] exp_a, exp_b, exp_lomask, exp_soft;
    always @(negedge clk) begin
        if (arr_cmd != 3'd0 && req_ready) bad_rdy++;
        case (arr_cmd)
            3'd1: begin n_hi++;  if (arr_mask != '1 || arr_wdata != exp_a) bad_hi++; end
            3'd2: begin n_lo++;  if (arr_mask != exp_lomask || arr_wdata != exp_b) bad_lo++; end
            3'd3: n_mid++;
            3'd4: begin n_sel++; if (arr_ref_hi != exp_soft) bad_sel++; end
            default: ;
        endcase
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_hi = 0; n_lo = 0; n_mid = 0; n_sel = 0;
        bad_hi = 0; bad_lo = 0; bad_sel = 0; bad_rdy = 0;
    endtask

    task automatic issue(input bit wr, input bit pr, input int ad, input int a, input int b);
        req_valid = 1'b1; req_write = wr; req_paired = pr;
        req_addr = AW'(ad); req_wa = W'(a); req_wb = W'(b);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input bit pr, input int ad, input int a, input int b);
        int t, ones;
        clr_mon();
        exp_a = W'(a); exp_b = W'(b);
        exp_lomask = pr ? W'(a ^ b) : '1;
        ones = $countones(exp_lomask);
        issue(1'b1, pr, ad, a, b);
        chk(!req_ready, "R8 ready low after accept", int'(req_ready), 0);
        t = 0;
        while (!wr_done && t < 200) begin @(negedge clk); t++; end
        chk(wr_done == 1'b1, "R9 write done strobe", int'(wr_done), 1);
        chk(int'(wr_flip_cnt) == ones, "R9 low-current cell count", int'(wr_flip_cnt), ones);
        chk(n_hi == (pr ? HC : 0), pr ? "R2 high step length" : "R6 no high step", n_hi, pr ? HC : 0);
        chk(bad_hi == 0, "R2 high step mask/data", bad_hi, 0);
        chk(n_lo == ((!pr || a != b) ? SC : 0), pr ? "R3 low step length/skip" : "R6 low step length",
            n_lo, (!pr || a != b) ? SC : 0);
        chk(bad_lo == 0, pr ? "R3 low step mask/data" : "R6 low step mask/data", bad_lo, 0);
        chk(n_mid + n_sel == 0, "R4 no compare during write", n_mid + n_sel, 0);
        chk(bad_rdy == 0, "R8 ready low while busy", bad_rdy, 0);
        @(negedge clk);
        chk(!wr_done && req_ready, "R9 strobe one cycle, ready back", int'(wr_done), 0);
    endtask

    task automatic do_read(input bit pr, input int ad, input int a, input int b);
        int t;
        logic [W-1:0] ra, rb;
        clr_mon();
        exp_soft = W'(b);
        issue(1'b0, pr, ad, 0, 0);
        t = 0;
        while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
        chk(rsp_valid == 1'b1, "R10 response raised", int'(rsp_valid), 1);
        ra = rsp_a; rb = rsp_b;
        @(negedge clk); @(negedge clk);
        chk(rsp_valid && rsp_a == ra && rsp_b == rb, "R10 response held", int'(rsp_b), int'(rb));
        chk(!req_ready, "R8 ready low while response waits", int'(req_ready), 0);
        chk(n_mid == RC, pr ? "R5 middle compare length" : "R7 single compare length", n_mid, RC);
        chk(n_sel == (pr ? RC : 0), pr ? "R5 selected compare length" : "R7 no second compare",
            n_sel, pr ? RC : 0);
        chk(bad_sel == 0, "R5 per-cell reference choice", bad_sel, 0);
        chk(int'(rsp_a) == (pr ? a : 0), pr ? "R5 hard bits read" : "R7 hard field zero", int'(rsp_a), pr ? a : 0);
        chk(int'(rsp_b) == b, pr ? "R5 soft bits read" : "R7 soft bits read", int'(rsp_b), b);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R10 response dropped after take", int'(rsp_valid), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        clr_mon();
        exp_a = '0; exp_b = '0; exp_lomask = '0; exp_soft = '0;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !wr_done && arr_cmd == 3'd0, "R1 state in reset",
            int'(arr_cmd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !wr_done && arr_cmd == 3'd0, "R1 state after reset",
            int'({req_ready, rsp_valid}), 2);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int ad, nb;
                ad = (a + b) % DEPTH;
                nb = (~b) & 15;
                do_write(1'b1, ad, a, b);
                do_read(1'b1, ad, a, b);
                do_write(1'b0, ad, 0, nb);   // R6: hard bits must survive
                do_read(1'b1, ad, a, nb);
                do_read(1'b0, ad, 0, nb);    // R7
            end
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule